// File: doc/BRIEF.md
# Run-Length Sample Expander with Capture Limits

This block takes a compressed stream from a nine-channel logic capture front end and turns it back into one sample per output beat. Each 16-bit input word carries a repeat count and one nine-bit sample value. The block sends that value out as many times as the count says, over a valid/ready output, and stalls its input until the whole run has been accepted downstream.

A capture begins with a one-cycle `start` pulse. The front end sends dummy all-zero data for a while after each start, so a fixed number of leading input bytes is dropped without producing output. The capture can be bounded by a sample count, by a time in milliseconds (converted at a fixed samples-per-millisecond rate, 100,000 by default for a 100 MHz sample clock), or by both. When the first active bound is hit, output stops on exactly that sample, even in the middle of a run, and a sticky `done` flag is raised. After that, further input is accepted and thrown away.

Top module: `rle_expander`

## Requirements
- R1: An input word is read as two bytes. `in_word[7:0]` is the first byte: bits 7:1 hold the repeat count (0 to 127) and bit 0 holds channel 9. `in_word[15:8]` is the second byte and holds channels 1 to 8.
- R2: Every output sample has channels 1 to 8 in `out_sample[7:0]` and channel 9 in `out_sample[8]`. Bits 15:9 are always zero.
- R3: A kept word with repeat count N produces exactly N output beats of its sample value, in the order the words arrived. A count of 0 produces no beat.
- R4: While a run still has beats pending, `in_ready` is low. `out_valid` and `out_sample` stay steady until `out_ready` takes each beat.
- R5: After reset or `start`, the first DISCARD_BYTES input bytes (DISCARD_BYTES/2 words) are accepted and produce no output.
- R6: With a nonzero `limit_samples`, exactly that many beats are sent after `start`, even if this cuts a run short. `done` is then set.
- R7: With a nonzero `limit_ms`, exactly SAMPLES_PER_MS × `limit_ms` beats are sent, and then `done` is set.
- R8: A limit of zero is disabled. With both limits nonzero, the smaller bound applies. With both at zero, the capture never ends.
- R9: While `done` is high, `out_valid` is low, `in_ready` is high, and words are accepted and dropped.
- R10: `start` clears `done`, the beat count, the discard window and any pending run.
- R11: After reset, `out_valid` and `done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a new capture |
| limit_samples | input | CNT_W | Sample-count bound, 0 = off |
| limit_ms | input | MS_W | Time bound in milliseconds, 0 = off |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_word | input | 16 | Compressed word (count, channel 9, channels 1–8) |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes the sample |
| out_sample | output | 16 | Expanded sample |
| done | output | 1 | A capture limit has been reached |

## Verification
A wrong run counter shows up on the very next run as a beat count that is off by one. It also shows as `in_ready` rising while `out_valid` is still high. A wrong emitted-sample counter or limit select shows only at the end of the capture: the total number of beats before `done` is wrong, so the bench counts every beat against the bound it worked out itself. A discard counter that is off appears as output from a dummy word, or a lost first real word, straight after `start`. Each of these is visible within a few cycles of the word that triggers it.

// File: rtl/rle_pkg.sv
package rle_pkg;
    localparam int SAMPLE_W = 16;
    localparam int RUN_W    = 7;
    localparam int LOW_W    = 8;

    function automatic logic [RUN_W-1:0] word_count(input logic [15:0] w);
        return w[7:1];
    endfunction

    function automatic logic [SAMPLE_W-1:0] word_sample(input logic [15:0] w);
        return {7'b0, w[0], w[15:8]};
    endfunction
endpackage

// File: rtl/rle_limit_calc.sv
module rle_limit_calc #(
    parameter int CNT_W          = 48,
    parameter int MS_W           = 16,
    parameter int SAMPLES_PER_MS = 100000
) (
    input  logic [CNT_W-1:0] limit_samples,
    input  logic [MS_W-1:0]  limit_ms,
    output logic             lim_en,
    output logic [CNT_W-1:0] lim_val
);
    localparam logic [CNT_W-1:0] RATE = CNT_W'(SAMPLES_PER_MS);

    logic [CNT_W-1:0] time_lim;
    logic             s_en, t_en;

    always_comb begin
        time_lim = CNT_W'(limit_ms) * RATE;
        s_en     = (limit_samples != '0);
        t_en     = (limit_ms != '0);
        lim_en   = s_en | t_en;
        if (s_en && t_en)
            lim_val = (limit_samples < time_lim) ? limit_samples : time_lim;
        else if (s_en)
            lim_val = limit_samples;
        else
            lim_val = time_lim;
    end
endmodule

// File: rtl/rle_discard_window.sv
module rle_discard_window #(
    parameter int DISCARD_BYTES = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic accept,
    output logic in_window
);
    localparam int DISCARD_WORDS = (DISCARD_BYTES + 1) / 2;
    localparam int DW = $clog2(DISCARD_WORDS + 1);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        in_window = (cnt_q < DW'(DISCARD_WORDS));
        cnt_d     = cnt_q;
        if (start)
            cnt_d = '0;
        else if (accept && in_window)
            cnt_d = cnt_q + DW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rle_run_engine.sv
module rle_run_engine
    import rle_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                load,
    input  logic [15:0]         word,
    input  logic                lim_en,
    input  logic [CNT_W-1:0]    lim_val,
    input  logic                out_ready,
    output logic                busy,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                done
);
    typedef struct packed {
        logic [RUN_W-1:0]    run;
        logic [SAMPLE_W-1:0] smp;
        logic [CNT_W-1:0]    emitted;
        logic                done;
    } eng_t;

    eng_t st_d, st_q;
    logic fire, last_beat;

    always_comb begin
        busy       = (st_q.run != '0);
        out_valid  = busy;
        out_sample = st_q.smp;
        done       = st_q.done;
        fire       = out_valid && out_ready;
        last_beat  = lim_en && ((st_q.emitted + CNT_W'(1)) >= lim_val);

        st_d = st_q;
        if (start) begin
            st_d = '0;
        end else begin
            if (fire) begin
                st_d.run     = st_q.run - RUN_W'(1);
                st_d.emitted = st_q.emitted + CNT_W'(1);
                if (last_beat) begin
                    st_d.done = 1'b1;
                    st_d.run  = '0;
                end
            end
            if (load && !st_q.done) begin
                st_d.run = word_count(word);
                st_d.smp = word_sample(word);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rle_expander.sv
module rle_expander #(
    parameter int DISCARD_BYTES  = 65536,
    parameter int SAMPLES_PER_MS = 100000,
    parameter int CNT_W          = 48,
    parameter int MS_W           = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] limit_samples,
    input  logic [MS_W-1:0]  limit_ms,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [15:0]      in_word,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [15:0]      out_sample,
    output logic             done
);
    logic             lim_en;
    logic [CNT_W-1:0] lim_val;
    logic             busy, accept, in_window, load;

    always_comb begin
        in_ready = !busy;
        accept   = in_valid && in_ready && !start;
        load     = accept && !in_window;
    end

    rle_limit_calc #(
        .CNT_W(CNT_W), .MS_W(MS_W), .SAMPLES_PER_MS(SAMPLES_PER_MS)
    ) u_lim (
        .limit_samples(limit_samples),
        .limit_ms     (limit_ms),
        .lim_en       (lim_en),
        .lim_val      (lim_val)
    );

    rle_discard_window #(.DISCARD_BYTES(DISCARD_BYTES)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .accept   (accept),
        .in_window(in_window)
    );

    rle_run_engine #(.CNT_W(CNT_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load      (load),
        .word      (in_word),
        .lim_en    (lim_en),
        .lim_val   (lim_val),
        .out_ready (out_ready),
        .busy      (busy),
        .out_valid (out_valid),
        .out_sample(out_sample),
        .done      (done)
    );
endmodule

// File: rtl/rle_expander_chk.sv
module rle_expander_chk #(
    parameter int DISCARD_BYTES = 65536,
    parameter int CNT_W         = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] limit_samples,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [15:0]      out_sample,
    input logic             done
);
    localparam int DISCARD_WORDS = (DISCARD_BYTES + 1) / 2;
    localparam int DW = $clog2(DISCARD_WORDS + 1);

    logic [CNT_W-1:0] beats_q;
    logic [DW-1:0]    words_q;

    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            beats_q <= '0;
            words_q <= '0;
        end else begin
            if (out_valid && out_ready) beats_q <= beats_q + CNT_W'(1);
            if (in_valid && in_ready && words_q < DW'(DISCARD_WORDS))
                words_q <= words_q + DW'(1);
        end
    end

    a_r4_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    a_r4_hold_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_sample)));
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sample[15:9] == 7'd0));
    a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && in_ready));
    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !out_valid));
    a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_samples != '0 && !start) |-> (beats_q <= limit_samples));
    a_r5_window_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (words_q < DW'(DISCARD_WORDS)) |-> !out_valid);
endmodule

bind rle_expander rle_expander_chk #(
    .DISCARD_BYTES(DISCARD_BYTES), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .limit_samples(limit_samples),
    .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_sample(out_sample), .done(done)
);

// File: tb/sim_rle_expander.sv
module sim_rle_expander;
    localparam int DISC  = 8;
    localparam int NDISC = DISC / 2;
    localparam int SPM   = 10;
    localparam int CW    = 32;
    localparam int MW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] limit_samples = '0;
    logic [MW-1:0] limit_ms = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [15:0]   in_word = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [15:0]   out_sample;
    logic          done;

    int checks = 0, errors = 0;
    logic [15:0] cap [0:63];
    int cap_n = 0, proto_err = 0;
    logic toggle_rdy = 1'b0;
    logic prev_stall = 1'b0;
    logic [15:0] prev_smp = '0;

    always #2.5 clk = ~clk;

    rle_expander #(.DISCARD_BYTES(DISC), .SAMPLES_PER_MS(SPM), .CNT_W(CW), .MS_W(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .limit_samples(limit_samples),
        .limit_ms(limit_ms), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample), .done(done));

    always @(posedge clk) begin
        #1;
        if (toggle_rdy) out_ready = ~out_ready;
        else            out_ready = 1'b1;
    end

    always @(negedge clk) begin
        if (out_valid && in_ready) proto_err++;
        if (prev_stall && (!out_valid || out_sample != prev_smp)) proto_err++;
        prev_stall = out_valid && !out_ready;
        prev_smp   = out_sample;
        if (out_valid && out_ready) begin
            if (cap_n < 64) cap[cap_n] = out_sample;
            cap_n++;
        end
    end

    function automatic logic [15:0] mkw(input int cnt, input logic c9, input logic [7:0] lo);
        return {lo, cnt[6:0], c9};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(posedge clk); #1;
        in_valid = 1'b1; in_word = w;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic begin_capture(input int ls, input int lm);
        @(posedge clk); #1;
        limit_samples = CW'(ls); limit_ms = MW'(lm); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        cap_n = 0;
    endtask

    task automatic flush_window();
        for (int i = 0; i < NDISC; i++) send(mkw(5, 1'b1, 8'hFF));
    endtask

    task automatic settle();
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (!out_valid && in_ready) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_run(input string req, input int from, input int n, input logic [15:0] v);
        for (int i = from; i < from + n; i++) check(req, 32'(cap[i]), 32'(v));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11 out_valid", 32'(out_valid), 0);
        check("R11 done", 32'(done), 0);
        check("R11 in_ready", 32'(in_ready), 1);
    endtask

    task automatic t_discard_and_format();
        begin_capture(0, 0);
        flush_window();
        settle();
        check("R5 no output in window", 32'(cap_n), 0);
        send(mkw(3, 1'b1, 8'hA5));
        settle();
        check("R3 beat count", 32'(cap_n), 3);
        check_run("R1 R2 sample", 0, 3, 16'h01A5);
        send(mkw(2, 1'b0, 8'h3C));
        settle();
        check("R3 order", 32'(cap_n), 5);
        check_run("R2 ch9 clear", 3, 2, 16'h003C);
    endtask

    task automatic t_zero_count();
        begin_capture(0, 0);
        flush_window();
        send(mkw(0, 1'b1, 8'h11));
        settle();
        check("R3 zero count silent", 32'(cap_n), 0);
        send(mkw(127, 1'b0, 8'h22));
        settle();
        check("R1 max count", 32'(cap_n), 127);
        check("R8 unlimited no done", 32'(done), 0);
    endtask

    task automatic t_backpressure();
        begin_capture(0, 0);
        flush_window();
        proto_err = 0;
        toggle_rdy = 1'b1;
        send(mkw(6, 1'b1, 8'h5A));
        send(mkw(3, 1'b0, 8'h77));
        settle();
        toggle_rdy = 1'b0;
        check("R4 count under stall", 32'(cap_n), 9);
        check_run("R4 values", 0, 6, 16'h015A);
        check_run("R4 values b", 6, 3, 16'h0077);
        check("R4 hold and input stall", 32'(proto_err), 0);
    endtask

    task automatic t_sample_limit();
        begin_capture(7, 0);
        flush_window();
        send(mkw(5, 1'b0, 8'h01));
        send(mkw(5, 1'b1, 8'h02));
        settle();
        check("R6 truncated total", 32'(cap_n), 7);
        check_run("R6 tail", 5, 2, 16'h0102);
        check("R6 done", 32'(done), 1);
        send(mkw(4, 1'b0, 8'h33));
        settle();
        check("R9 dropped after done", 32'(cap_n), 7);
        check("R9 in_ready", 32'(in_ready), 1);
        check("R9 done sticky", 32'(done), 1);
    endtask

    task automatic t_exact_boundary();
        begin_capture(5, 0);
        flush_window();
        send(mkw(5, 1'b0, 8'h44));
        settle();
        check("R6 boundary total", 32'(cap_n), 5);
        check("R6 boundary done", 32'(done), 1);
    endtask

    task automatic t_time_limit();
        begin_capture(0, 1);
        flush_window();
        for (int i = 0; i < 3; i++) send(mkw(4, 1'b1, 8'h80));
        settle();
        check("R7 time total", 32'(cap_n), SPM);
        check("R7 done", 32'(done), 1);
    endtask

    task automatic t_both_limits();
        begin_capture(13, 1);
        flush_window();
        for (int i = 0; i < 4; i++) send(mkw(4, 1'b0, 8'h09));
        settle();
        check("R8 time smaller", 32'(cap_n), SPM);
        begin_capture(6, 2);
        check("R10 done cleared", 32'(done), 0);
        flush_window();
        settle();
        check("R10 window reapplied", 32'(cap_n), 0);
        for (int i = 0; i < 3; i++) send(mkw(4, 1'b0, 8'h0A));
        settle();
        check("R8 count smaller", 32'(cap_n), 6);
        check("R8 done", 32'(done), 1);
    endtask

    task automatic t_start_midrun();
        begin_capture(0, 0);
        flush_window();
        toggle_rdy = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b1; in_word = mkw(100, 1'b0, 8'h66);
        @(posedge clk); #1;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        begin_capture(0, 0);
        toggle_rdy = 1'b0;
        @(negedge clk);
        check("R10 pending run cleared", 32'(out_valid), 0);
        check("R10 ready after start", 32'(in_ready), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_discard_and_format();
        t_zero_count();
        t_backpressure();
        t_sample_limit();
        t_exact_boundary();
        t_time_limit();
        t_both_limits();
        t_start_midrun();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule